// File: doc/BRIEF.md
# Contactless Tag ID Frame Receiver

This block sits behind a tag demodulator and bit-clock recovery stage. It accepts an already decoded serial bit stream, one bit per accepted transfer, and finds the 64-bit identification frame inside it. Frames are located by a header run of ones. The parity layout of the frame makes such a run impossible anywhere else. After the header the receiver takes in a grid of data rows. Each row ends in a row parity bit. A row of column parity bits and a single stop bit follow the grid. Every parity bit is checked as it arrives. A frame that passes every check is delivered as a 40-bit ID with a one-cycle valid pulse. A frame that fails any check is dropped with a one-cycle error pulse, and the receiver goes back to hunting for a header.

The input is a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and a bit is consumed on every clock edge where `in_valid` is high. Cycles with `in_valid` low carry no bit. The output side has no handshake. The ID is a held register, and `id_valid` marks the cycle in which it was refreshed.

Header length, row count and column count are parameters. The ID width is rows × columns.

Top module: `rfid_id_receiver`

## Requirements
- R1: A frame starts once HDR_LEN (default 9) consecutive 1 bits have been accepted. The bit after the last header 1 is the first data bit. A 0 bit restarts the run count.
- R2: After the header come ROWS (default 10) rows. Each row holds COLS (default 4) data bits followed by one even row parity bit, so the five bits of a row XOR to 0. A failing row parity bit rejects the frame in the cycle that bit is accepted.
- R3: After the last row come COLS even column parity bits, one per column, in column order. Column c's parity bit XORs to 0 with data bit c of every row. A failing column parity bit rejects the frame at once.
- R4: The last frame bit is a stop bit. A frame is accepted only if the stop bit is 0, and a 1 rejects the frame.
- R5: A frame is accepted when its stop bit is taken. One clock after that edge, `id_valid` is high for exactly one cycle and `id_data` holds the 40 data bits in arrival order, the first received data bit at bit 39. The version/customer field is therefore `id_data[39:32]`.
- R6: `id_data` changes only when a frame is accepted. Between accepted frames it holds its value, and rejected frames leave it unchanged.
- R7: Each rejected frame produces exactly one one-cycle `frame_err` pulse, one clock after the failing bit is taken. `frame_err` and `id_valid` are never high together.
- R8: After a rejection the header search resumes with the count of consecutive 1s that end at the failing bit (that bit included), header bits included. If that count already reaches HDR_LEN, the next accepted bit is the first data bit of a new frame.
- R9: `in_ready` is always 1. Cycles with `in_valid` low change no state and raise no pulse, whatever `in_bit` carries.
- R10: While `rst_n` is low, `id_valid` and `frame_err` are 0, `id_data` is all zero, and the receiver is hunting with a run count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded bit is present on `in_bit` |
| in_ready | output | 1 | Always 1; the block never stalls the stream |
| in_bit | input | 1 | Decoded serial data bit |
| id_valid | output | 1 | One-cycle pulse: a checked frame has been loaded into `id_data` |
| id_data | output | 40 | ID of the most recent accepted frame, first received data bit at the MSB |
| frame_err | output | 1 | One-cycle pulse: the current frame was rejected |

## Verification
The bench builds the receiver with its default parameters: a 9-bit header, 10 rows and 4 columns. With these values the frame is exactly 64 bits, so the frames the bench builds match real tag frames bit for bit. They also make the header's uniqueness argument hold, which the bench relies on when it drops a single 1 from a random frame and expects exactly one rejection with no false resync. The directed cases exercise the two resync paths at this header length. In the first, a row fails with one trailing 1 and 8 more ones complete a header. In the second, a failing all-ones row pushes the run past 9 and data starts on the very next bit.

// File: rtl/rfid_rx_pkg.sv
package rfid_rx_pkg;

  // Receiver phases across one frame.
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,  // looking for the header run
    ST_ROWS = 2'd1,  // data bits and row parity
    ST_COLS = 2'd2,  // column parity bits
    ST_STOP = 2'd3   // final stop bit
  } rx_state_e;

endpackage

// File: rtl/rfid_run_count.sv
// Saturating count of consecutive 1s over accepted bits. The next value is
// exposed combinationally so the controller can act on the current bit.
module rfid_run_count #(
  parameter int HDR_LEN = 9,
  parameter int RUN_W   = $clog2(HDR_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bit_i,
  output logic [RUN_W-1:0] run_nx,
  output logic             hdr_hit
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(HDR_LEN);

  logic [RUN_W-1:0] run_q;

  always_comb begin
    if (!bit_i)              run_nx = '0;
    else if (run_q >= RUN_MAX) run_nx = RUN_MAX;
    else                     run_nx = run_q + 1'b1;
  end

  assign hdr_hit = (run_nx == RUN_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (take) run_q <= run_nx;
  end

  // R1: an accepted zero always restarts the run.
  p_zero_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bit_i) |=> (run_q == '0));

  // R9: idle cycles leave the run untouched.
  p_idle_keeps_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(run_q));

endmodule

// File: rtl/rfid_parity_track.sv
// Running row parity and one running parity per column, compared against the
// incoming parity bit combinationally.
module rfid_parity_track #(
  parameter int COLS  = 4,
  parameter int COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             data_take,
  input  logic             row_close,
  input  logic             bit_i,
  input  logic [COL_W-1:0] col_idx,
  output logic             row_ok,
  output logic             col_ok
);

  logic            row_q;
  logic [COLS-1:0] col_q;
  logic            col_sel;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   row_q <= 1'b0;
    else if (row_close)  row_q <= 1'b0;
    else if (data_take)  row_q <= row_q ^ bit_i;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        col_q[c] <= 1'b0;
      else if (data_take && (col_idx == COL_W'(c)))
        col_q[c] <= col_q[c] ^ bit_i;
    end
  end

  always_comb begin
    col_sel = 1'b0;
    for (int c = 0; c < COLS; c++)
      if (col_idx == COL_W'(c)) col_sel = col_q[c];
  end

  assign row_ok = ~(row_q ^ bit_i);
  assign col_ok = ~(col_sel ^ bit_i);

  // R2: a fresh frame starts with a clean row accumulator.
  p_clear_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (row_q == 1'b0));

endmodule

// File: rtl/rfid_frame_ctrl.sv
// Frame sequencer: walks the frame layout, shifts in the ID, decides
// accept or reject, and restarts the hunt on failure.
module rfid_frame_ctrl
  import rfid_rx_pkg::*;
#(
  parameter int ROWS  = 10,
  parameter int COLS  = 4,
  parameter int ID_W  = ROWS * COLS,
  parameter int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  parameter int COL_W = $clog2(COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bit_i,
  input  logic             hdr_hit,
  input  logic             row_ok,
  input  logic             col_ok,
  output logic             clr,
  output logic             data_take,
  output logic             row_close,
  output logic [COL_W-1:0] col_idx,
  output logic             id_valid,
  output logic [ID_W-1:0]  id_data,
  output logic             frame_err
);

  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [COL_W-1:0] COL_PAR  = COL_W'(COLS);

  rx_state_e        state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ID_W-1:0]  sr_q, id_q;
  logic             vld_q, err_q;
  logic             accept, abort, start;

  always_comb begin
    state_d   = state_q;
    row_d     = row_q;
    col_d     = col_q;
    accept    = 1'b0;
    abort     = 1'b0;
    start     = 1'b0;
    data_take = 1'b0;
    row_close = 1'b0;
    if (take) begin
      unique case (state_q)
        ST_HUNT: if (hdr_hit) start = 1'b1;
        ST_ROWS: begin
          if (col_q < COL_PAR) begin
            data_take = 1'b1;
            col_d     = col_q + 1'b1;
          end else if (row_ok) begin
            row_close = 1'b1;
            col_d     = '0;
            if (row_q == ROW_LAST) begin
              state_d = ST_COLS;
              row_d   = '0;
            end else begin
              row_d   = row_q + 1'b1;
            end
          end else begin
            abort = 1'b1;
          end
        end
        ST_COLS: begin
          if (!col_ok)               abort   = 1'b1;
          else if (col_q == COL_LAST) state_d = ST_STOP;
          else                        col_d   = col_q + 1'b1;
        end
        ST_STOP: begin
          if (!bit_i) begin
            accept  = 1'b1;
            state_d = ST_HUNT;
          end else begin
            abort   = 1'b1;
          end
        end
        default: state_d = ST_HUNT;
      endcase
      if (abort) begin
        if (hdr_hit) start   = 1'b1;
        else         state_d = ST_HUNT;
      end
      if (start) begin
        state_d = ST_ROWS;
        row_d   = '0;
        col_d   = '0;
      end
    end
  end

  assign clr     = start;
  assign col_idx = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      row_q   <= '0;
      col_q   <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      vld_q   <= accept;
      err_q   <= abort;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         sr_q <= '0;
    else if (data_take) sr_q <= {sr_q[ID_W-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      id_q <= '0;
    else if (accept) id_q <= sr_q;
  end

  assign id_valid  = vld_q;
  assign id_data   = id_q;
  assign frame_err = err_q;

  // R7: accept and reject never coincide.
  p_excl_events_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(id_valid && frame_err));

  // R4: acceptance follows an accepted zero stop bit.
  p_stop_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(take && !bit_i));

  // R7: a rejection is always caused by an accepted bit.
  p_err_from_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(take));

  // R5: the valid strobe lasts one cycle.
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  // R6: the ID moves only together with the valid strobe.
  p_hold_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> $stable(id_data));

  // R9: idle cycles raise no event.
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (!id_valid && !frame_err));

endmodule

// File: rtl/rfid_id_receiver.sv
module rfid_id_receiver #(
  parameter int HDR_LEN = 9,
  parameter int ROWS    = 10,
  parameter int COLS    = 4,
  localparam int ID_W   = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_bit,
  output logic            id_valid,
  output logic [ID_W-1:0] id_data,
  output logic            frame_err
);

  localparam int RUN_W = $clog2(HDR_LEN + 1);
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = $clog2(COLS + 1);

  logic             take;
  logic [RUN_W-1:0] run_nx;
  logic             hdr_hit;
  logic             clr, data_take, row_close;
  logic [COL_W-1:0] col_idx;
  logic             row_ok, col_ok;

  assign in_ready = 1'b1;
  assign take     = in_valid;

  rfid_run_count #(.HDR_LEN(HDR_LEN), .RUN_W(RUN_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .bit_i   (in_bit),
    .run_nx  (run_nx),
    .hdr_hit (hdr_hit)
  );

  rfid_parity_track #(.COLS(COLS), .COL_W(COL_W)) u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .data_take (data_take),
    .row_close (row_close),
    .bit_i     (in_bit),
    .col_idx   (col_idx),
    .row_ok    (row_ok),
    .col_ok    (col_ok)
  );

  rfid_frame_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .ID_W(ID_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .bit_i     (in_bit),
    .hdr_hit   (hdr_hit),
    .row_ok    (row_ok),
    .col_ok    (col_ok),
    .clr       (clr),
    .data_take (data_take),
    .row_close (row_close),
    .col_idx   (col_idx),
    .id_valid  (id_valid),
    .id_data   (id_data),
    .frame_err (frame_err)
  );

  // R1: the run value offered to the controller never exceeds the header length.
  p_run_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_nx <= RUN_W'(HDR_LEN));

endmodule

// File: tb/sim_rfid_id_receiver.sv
module sim_rfid_id_receiver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_bit = 1'b0;
  logic        in_ready;
  logic        id_valid;
  logic        frame_err;
  logic [39:0] id_data;

  int total = 0;
  int bad = 0;
  int nvalid = 0;
  int nerr = 0;
  logic [39:0] last_id = '0;
  bit done = 0;

  always #5 clk = ~clk;

  rfid_id_receiver u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .id_valid(id_valid), .id_data(id_data), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe();
    if (id_valid) begin nvalid++; last_id = id_data; end
    if (frame_err) nerr++;
  endtask

  task automatic clear_counts();
    nvalid = 0;
    nerr = 0;
  endtask

  task automatic send_bit(input logic b, input bit gaps);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    observe();
    in_valid = 1'b0;
    if (gaps && ($urandom % 4 == 0)) begin
      repeat (1 + $urandom % 3) begin
        in_bit = 1'($urandom);
        @(negedge clk);
        observe();
      end
    end
  endtask

  task automatic send_seq(input logic [63:0] v, input int n, input bit gaps);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], gaps);
  endtask

  // Frame bit 63 goes out first: 9 ones, 10 rows of data+even parity,
  // 4 even column parity bits, stop 0.
  function automatic logic [63:0] mk_frame(input logic [39:0] id);
    logic [63:0] f;
    logic [3:0]  d, cp;
    int          p;
    f  = '0;
    cp = '0;
    p  = 63;
    for (int k = 0; k < 9; k++) begin f[p] = 1'b1; p--; end
    for (int r = 0; r < 10; r++) begin
      d = id[39 - 4*r -: 4];
      for (int c = 0; c < 4; c++) begin f[p] = d[3-c]; p--; end
      f[p] = ^d; p--;
      cp = cp ^ d;
    end
    for (int c = 0; c < 4; c++) begin f[p] = cp[3-c]; p--; end
    f[p] = 1'b0;
    return f;
  endfunction

  task automatic expect_good(input logic [39:0] id, input string tag);
    chk(nvalid == 1, {tag, " R5 valid pulses"}, nvalid, 1);
    chk(nerr == 0, {tag, " R7 no error"}, nerr, 0);
    chk(last_id == id, {tag, " R5 id"}, last_id, id);
    chk(id_data == id, {tag, " R6 id held"}, id_data, id);
  endtask

  task automatic expect_reject(input logic [39:0] prev, input string tag);
    chk(nerr == 1, {tag, " R7 one error"}, nerr, 1);
    chk(nvalid == 0, {tag, " no accept"}, nvalid, 0);
    chk(id_data == prev, {tag, " R6 id unchanged"}, id_data, prev);
  endtask

  task automatic good_frame(input logic [39:0] id, input bit gaps, input string tag);
    clear_counts();
    send_seq(mk_frame(id), 64, gaps);
    expect_good(id, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] f;
    logic [39:0] id, prev;
    void'($urandom(32'd7319));

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(id_valid == 1'b0, "R10 id_valid", id_valid, 0);
    chk(frame_err == 1'b0, "R10 frame_err", frame_err, 0);
    chk(id_data == '0, "R10 id_data", id_data, 0);
    chk(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5: plain frame, version field in the top byte
    good_frame(40'h12_3456_789A, 1'b0, "direct1");
    chk(id_data[39:32] == 8'h12, "R5 version field", id_data[39:32], 8'h12);
    // back-to-back frame with no gap
    good_frame(40'hA5_0F0F_C3E1, 1'b0, "direct2");

    // R9: idle cycles with a toggling data line
    clear_counts();
    in_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      in_bit = i[0];
      @(negedge clk);
      observe();
    end
    chk(nvalid == 0 && nerr == 0, "R9 idle no events", nvalid + nerr, 0);
    chk(id_data == 40'hA5_0F0F_C3E1, "R9 idle id held", id_data, 40'hA5_0F0F_C3E1);
    // header split by idle cycles, then frame
    good_frame(40'h0F_1234_5678, 1'b1, "R9 gaps");

    // R8: row fails ending in a single 1, eight more ones finish a header
    clear_counts();
    send_seq(64'h1FF, 9, 1'b0);
    send_seq(64'b01101, 5, 1'b0);
    chk(nerr == 1, "R2 bad row parity", nerr, 1);
    id = 40'h3C_5A69_0011;
    send_seq(64'hFF, 8, 1'b0);
    send_seq(mk_frame(id), 55, 1'b0);
    chk(nvalid == 1, "R8 trailing-one resync", nvalid, 1);
    chk(last_id == id, "R8 trailing-one id", last_id, id);

    // R8: failing all-ones row leaves a saturated run, data starts next bit
    clear_counts();
    send_seq(64'h1FF, 9, 1'b0);
    send_seq(64'b11111, 5, 1'b0);
    id = 40'h77_8899_AABB;
    send_seq(mk_frame(id), 55, 1'b0);
    chk(nerr == 1, "R8 saturated abort", nerr, 1);
    chk(nvalid == 1, "R8 saturated resync", nvalid, 1);
    chk(last_id == id, "R8 saturated id", last_id, id);

    // R2: flipped row 0 parity (row 0 data 0001, parity 1 -> 0)
    prev = id_data;
    clear_counts();
    f = mk_frame(40'h1E_2D3C_4B5A);
    f[50] = 1'b0;
    send_seq(f, 64, 1'b0);
    expect_reject(prev, "R2 row parity");
    good_frame(40'h1E_2D3C_4B5A, 1'b0, "after R2");

    // R3: flipped first column parity bit
    prev = id_data;
    clear_counts();
    f = mk_frame(40'h98_7654_3210);
    f[4] = ~f[4];
    send_seq(f, 64, 1'b0);
    expect_reject(prev, "R3 column parity");
    send_bit(1'b0, 1'b0);
    good_frame(40'h98_7654_3210, 1'b0, "after R3");

    // R4: stop bit 1, then a separating zero
    prev = id_data;
    clear_counts();
    f = mk_frame(40'hCA_FE12_3456);
    f[0] = 1'b1;
    send_seq(f, 64, 1'b0);
    send_bit(1'b0, 1'b0);
    expect_reject(prev, "R4 stop bit");
    good_frame(40'hCA_FE12_3456, 1'b0, "after R4");

    // random good frames with random gaps
    for (int n = 0; n < 30; n++) begin
      id = {$urandom, $urandom} ;
      good_frame(id, 1'b1, "random good");
    end

    // random single 1->0 flips inside rows or column parity
    for (int n = 0; n < 25; n++) begin
      int k;
      id = {$urandom, $urandom};
      id[0] = 1'b1;
      f = mk_frame(id);
      do k = 1 + int'($urandom % 54); while (f[k] != 1'b1);
      f[k] = 1'b0;
      prev = id_data;
      clear_counts();
      send_seq(f, 64, 1'b1);
      expect_reject(prev, (k >= 5) ? "R2 random flip" : "R3 random flip");
      id = {$urandom, $urandom};
      good_frame(id, 1'b1, "R1 after flip");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule